// File: doc/BRIEF.md
# Multi-Row Challenge Mixing Network

This block sits between a challenge source and a bank of Q delay-based response rows. It turns one N-bit challenge into Q row challenges. Each row first gets its own rotated copy of the challenge. Rotations pile up from row to row: row r (counting from 0) ends up rotated by r(r-1)/2 positions. Each rotated vector then passes through a pairwise-XOR network. That network puts sums of odd-starting pairs in the lower half of the word and sums of even-starting pairs in the upper half. The response bits that the rows send back enter on a separate port. They are folded into M output bits by a sliding-window XOR, whose window width Z and starting offset S are set by parameters.

The two paths are independent. A strobed challenge gives registered row challenges one cycle later, with a one-cycle valid pulse. Strobed response bits give registered mixed outputs one cycle later, with their own valid pulse. A four-state machine records which paths captured on the last edge, and the two output valids are decoded from it. Its states are IDLE (nothing captured), CHAL (challenge only), RESP (responses only) and BOTH (both). From every state, the next state is chosen only by the pair {chal_valid, resp_valid} present on the edge:
- 00 goes to IDLE.
- 10 goes to CHAL.
- 01 goes to RESP.
- 11 goes to BOTH.

N must be even.

Top module: `chal_mix_net`

## Requirements
- R1: Row 0 and row 1 use the challenge unrotated. Row r (0-based, r ≥ 2) uses the challenge rotated by (r(r-1)/2) mod N. A rotation by k moves bit b to bit (b+k) mod N. Row r occupies bits [r*N +: N] of row_chal. For N=8, Q=4 and challenge 8'h01, row_chal is 32'h42201010.
- R2: Bit numbering here is 0-based, and x is a row's rotated vector. Output bit N/2 is x[0]. For each odd p from 3 to N-1, output bit (p-1)/2 is x[p-1]^x[p]. For each even p from 2 to N-2, output bit (N+p)/2 is x[p-1]^x[p].
- R3: Output bit 0 of every row's pair network, which no pair drives, is x[N-1].
- R4: mix_out[o] is the XOR of resp_in at indices (o+S+i) mod Q for i = 1..Z. With Q=4, S=1 and Z=2:
  - mix_out[0] = resp_in[2]^resp_in[3].
  - mix_out[1] = resp_in[3]^resp_in[0].
  - mix_out[2] = resp_in[0]^resp_in[1].
- R5: row_chal is loaded on the edge where chal_valid is high. row_valid is high for exactly the cycle after each such edge.
- R6: mix_out is loaded on the edge where resp_valid is high. mix_valid is high for exactly the cycle after each such edge, whatever chal_valid does.
- R7: When its strobe is low, each output register holds its previous value.
- R8: An active-low rst_n clears row_chal, mix_out, row_valid and mix_valid to 0.
- R9: When both strobes are high on the same edge, both paths load and both valids rise together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chal_valid | input | 1 | Challenge strobe |
| chal_in | input | N | Incoming challenge |
| resp_valid | input | 1 | Response strobe |
| resp_in | input | Q | One response bit per row |
| row_valid | output | 1 | Row challenges updated last edge |
| row_chal | output | Q*N | Packed row challenges, row r at [r*N +: N] |
| mix_valid | output | 1 | Mixed outputs updated last edge |
| mix_out | output | M | Windowed-XOR mixed response bits |

## Verification
Challenge capture and response mixing can land on the same edge. That drives the state machine into BOTH, and both registers have to load at once. The stimulus table raises chal_valid and resp_valid together in several rows and raises each strobe alone in others. Each row is judged one edge later: both valids must match the strobes applied, row_chal must equal the independently computed rotation-and-pair result, and mix_out must equal the hand-derived window XOR. A path whose strobe was low must show its previous value unchanged.

// File: rtl/cmx_pkg.sv
package cmx_pkg;

    typedef enum logic [1:0] {
        CMX_IDLE = 2'b00,
        CMX_RESP = 2'b01,
        CMX_CHAL = 2'b10,
        CMX_BOTH = 2'b11
    } cmx_state_e;

endpackage

// File: rtl/cmx_rotator.sv
module cmx_rotator #(
    parameter int W     = 8,
    parameter int SHIFT = 0
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int SH = SHIFT % W;

    for (genvar b = 0; b < W; b++) begin : g_bit
        assign dout[(b + SH) % W] = din[b];
    end
endmodule

// File: rtl/cmx_pairnet.sv
module cmx_pairnet #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] d
);
    localparam int HALF = W / 2;

    always_comb begin
        // every position starts at the top bit; only bit 0 keeps it
        d = {W{x[W-1]}};
        d[HALF] = x[0];
        for (int p = 3; p <= W - 1; p += 2) begin
            d[(p - 1) / 2] = x[p-1] ^ x[p];
        end
        for (int p = 2; p <= W - 2; p += 2) begin
            d[(W + p) / 2] = x[p-1] ^ x[p];
        end
    end
endmodule

// File: rtl/cmx_window_xor.sv
module cmx_window_xor #(
    parameter int ROWS = 4,
    parameter int OUTS = 3,
    parameter int WIN  = 2,
    parameter int OFS  = 1
) (
    input  logic [ROWS-1:0] r,
    output logic [OUTS-1:0] y
);
    always_comb begin
        for (int o = 0; o < OUTS; o++) begin
            y[o] = 1'b0;
            for (int i = 1; i <= WIN; i++) begin
                y[o] = y[o] ^ r[(o + OFS + i) % ROWS];
            end
        end
    end
endmodule

// File: rtl/chal_mix_net.sv
module chal_mix_net
    import cmx_pkg::*;
#(
    parameter int N = 8,
    parameter int Q = 4,
    parameter int M = 3,
    parameter int Z = 2,
    parameter int S = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           chal_valid,
    input  logic [N-1:0]   chal_in,
    input  logic           resp_valid,
    input  logic [Q-1:0]   resp_in,
    output logic           row_valid,
    output logic [Q*N-1:0] row_chal,
    output logic           mix_valid,
    output logic [M-1:0]   mix_out
);
    localparam int ROWBITS = Q * N;

    logic [ROWBITS-1:0] rot_flat;
    logic [ROWBITS-1:0] pair_flat;
    logic [M-1:0]       mix_next;
    cmx_state_e         state_q, state_d;

    assign rot_flat[N-1:0] = chal_in;

    // row r is row r-1 rotated by r-1: rotations accumulate
    for (genvar r = 1; r < Q; r++) begin : g_rot
        cmx_rotator #(.W(N), .SHIFT(r - 1)) u_rot (
            .din  (rot_flat[(r-1)*N +: N]),
            .dout (rot_flat[r*N +: N])
        );
    end

    for (genvar r = 0; r < Q; r++) begin : g_pair
        cmx_pairnet #(.W(N)) u_pair (
            .x (rot_flat[r*N +: N]),
            .d (pair_flat[r*N +: N])
        );
    end

    cmx_window_xor #(.ROWS(Q), .OUTS(M), .WIN(Z), .OFS(S)) u_win (
        .r (resp_in),
        .y (mix_next)
    );

    // next state: which paths capture on this edge
    always_comb begin
        unique case ({chal_valid, resp_valid})
            2'b00:   state_d = CMX_IDLE;
            2'b01:   state_d = CMX_RESP;
            2'b10:   state_d = CMX_CHAL;
            default: state_d = CMX_BOTH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CMX_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        unique case (state_q)
            CMX_IDLE: begin row_valid = 1'b0; mix_valid = 1'b0; end
            CMX_RESP: begin row_valid = 1'b0; mix_valid = 1'b1; end
            CMX_CHAL: begin row_valid = 1'b1; mix_valid = 1'b0; end
            CMX_BOTH: begin row_valid = 1'b1; mix_valid = 1'b1; end
            default:  begin row_valid = 1'b0; mix_valid = 1'b0; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_chal <= '0;
            mix_out  <= '0;
        end else begin
            if (chal_valid) row_chal <= pair_flat;
            if (resp_valid) mix_out  <= mix_next;
        end
    end
endmodule

// File: rtl/cmx_checker.sv
module cmx_checker #(
    parameter int N = 8,
    parameter int Q = 4,
    parameter int M = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           chal_valid,
    input logic [N-1:0]   chal_in,
    input logic           resp_valid,
    input logic [Q-1:0]   resp_in,
    input logic           row_valid,
    input logic [Q*N-1:0] row_chal,
    input logic           mix_valid,
    input logic [M-1:0]   mix_out
);
    a_r5_row_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        chal_valid |=> row_valid);
    a_r5_row_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !chal_valid |=> !row_valid);
    a_r6_mix_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> mix_valid);
    a_r6_mix_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |=> !mix_valid);
    a_r7_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chal_valid |=> $stable(row_chal));
    a_r7_mix_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |=> $stable(mix_out));
    a_r2_direct_bit: assert property (@(posedge clk) disable iff (!rst_n)
        chal_valid |=> row_chal[N/2] == $past(chal_in[0]));
    a_r3_tie_bit: assert property (@(posedge clk) disable iff (!rst_n)
        chal_valid |=> row_chal[0] == $past(chal_in[N-1]));
    a_r4_zero_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_in == '0) |=> mix_out == '0);
    a_r9_both_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (chal_valid && resp_valid) |=> (row_valid && mix_valid));
endmodule

bind chal_mix_net cmx_checker #(.N(N), .Q(Q), .M(M)) u_cmx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .chal_valid (chal_valid),
    .chal_in    (chal_in),
    .resp_valid (resp_valid),
    .resp_in    (resp_in),
    .row_valid  (row_valid),
    .row_chal   (row_chal),
    .mix_valid  (mix_valid),
    .mix_out    (mix_out)
);

// File: tb/chal_mix_net_bench.sv
`timescale 1ns/1ps
module chal_mix_net_bench;
    localparam int N = 8;
    localparam int Q = 4;
    localparam int M = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           chal_valid = 1'b0;
    logic [N-1:0]   chal_in = '0;
    logic           resp_valid = 1'b0;
    logic [Q-1:0]   resp_in = '0;
    logic           row_valid;
    logic [Q*N-1:0] row_chal;
    logic           mix_valid;
    logic [M-1:0]   mix_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    chal_mix_net #(.N(N), .Q(Q), .M(M), .Z(2), .S(1)) u_chal_mix_net (
        .clk(clk), .rst_n(rst_n), .chal_valid(chal_valid), .chal_in(chal_in),
        .resp_valid(resp_valid), .resp_in(resp_in), .row_valid(row_valid),
        .row_chal(row_chal), .mix_valid(mix_valid), .mix_out(mix_out)
    );

    always #2.5 clk = ~clk;

    typedef struct packed {
        logic [7:0] c;
        logic [3:0] r;
        logic       cv;
        logic       rv;
        logic [2:0] em;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t TBL [NV] = '{
        '{8'hA5, 4'b0001, 1'b1, 1'b1, 3'b110},
        '{8'h01, 4'b0110, 1'b1, 1'b0, 3'b110},
        '{8'h80, 4'b1000, 1'b0, 1'b1, 3'b011},
        '{8'hFF, 4'b1111, 1'b1, 1'b1, 3'b000},
        '{8'h3C, 4'b0101, 1'b1, 1'b1, 3'b111},
        '{8'h96, 4'b1100, 1'b0, 1'b0, 3'b111},
        '{8'h5A, 4'b0011, 1'b1, 1'b1, 3'b010}
    };

    // expected row challenges from the 1-based definitions
    function automatic logic [Q*N-1:0] exp_rows(input logic [N-1:0] c);
        logic [Q*N-1:0] res;
        logic [N:1] x;
        logic [N:1] d;
        int k;
        int p;
        res = '0;
        for (int r = 0; r < Q; r++) begin
            k = (r * (r - 1) / 2) % N;
            x = '0;
            for (int b = 1; b <= N; b++) begin
                p = (b + k) % N;
                if (p == 0) p = N;
                x[p] = c[b-1];
            end
            d = '0;
            d[1] = x[N];
            d[(N + 2) / 2] = x[1];
            for (int j = 2; j <= N - 1; j++) begin
                if (j % 2 == 1) d[(j + 1) / 2] = x[j] ^ x[j+1];
                else            d[(N + j + 2) / 2] = x[j] ^ x[j+1];
            end
            res[r*N +: N] = d;
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic cv, input logic [N-1:0] c, input logic rv, input logic [Q-1:0] r);
        @(negedge clk);
        chal_valid = cv; chal_in = c; resp_valid = rv; resp_in = r;
        @(posedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin : main
        logic [N-1:0] last_c;
        last_c = '0;
        // R8 reset state
        #1;
        check("R8 row_chal reset", 64'(row_chal), 64'h0);
        check("R8 mix_out reset", 64'(mix_out), 64'h0);
        check("R8 valids reset", {62'h0, row_valid, mix_valid}, 64'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // table walk: R1 R4 R5 R6 R7 R9
        for (int k = 0; k < NV; k++) begin
            step(TBL[k].cv, TBL[k].c, TBL[k].rv, TBL[k].r);
            if (TBL[k].cv) last_c = TBL[k].c;
            check(TBL[k].cv && TBL[k].rv ? "R9 row_valid" : "R5 row_valid",
                  64'(row_valid), 64'(TBL[k].cv));
            check(TBL[k].cv && TBL[k].rv ? "R9 mix_valid" : "R6 mix_valid",
                  64'(mix_valid), 64'(TBL[k].rv));
            check(TBL[k].cv ? "R1 row_chal" : "R7 row_chal hold",
                  64'(row_chal), 64'(exp_rows(last_c)));
            check(TBL[k].rv ? "R4 mix_out" : "R7 mix_out hold",
                  64'(mix_out), 64'(TBL[k].em));
        end

        // R5 valid is a single-cycle pulse
        step(1'b0, 8'h00, 1'b0, 4'h0);
        check("R5 row_valid drops", 64'(row_valid), 64'h0);
        check("R6 mix_valid drops", 64'(mix_valid), 64'h0);

        // R1 hand value: cumulative rotation plus pair network
        step(1'b1, 8'h01, 1'b0, 4'h0);
        check("R1 rows for 8'h01", 64'(row_chal), 64'h42201010);
        check("R2 row0 direct bit", 64'(row_chal[7:0]), 64'h10);

        // R2 pair sums: x1^x2 lands in upper half
        step(1'b1, 8'h02, 1'b0, 4'h0);
        check("R2 row0 for 8'h02", 64'(row_chal[7:0]), 64'h20);

        // R3 bit 0 tied to top input bit
        step(1'b1, 8'h80, 1'b0, 4'h0);
        check("R3 tie high", 64'(row_chal[0]), 64'h1);
        check("R3 full rows 8'h80", 64'(row_chal), 64'(exp_rows(8'h80)));
        step(1'b1, 8'h7F, 1'b0, 4'h0);
        check("R3 tie low", 64'(row_chal[0]), 64'h0);

        // R4 single response bits
        step(1'b0, 8'h00, 1'b1, 4'b0100);
        check("R4 resp row2", 64'(mix_out), 64'b001);
        step(1'b0, 8'h00, 1'b1, 4'b0010);
        check("R4 resp row1", 64'(mix_out), 64'b100);
        check("R7 row_chal hold during resp", 64'(row_chal), 64'(exp_rows(8'h7F)));

        // R8 reset mid-run
        @(negedge clk);
        chal_valid = 1'b0; resp_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R8 row_chal midrun", 64'(row_chal), 64'h0);
        check("R8 mix_out midrun", 64'(mix_out), 64'h0);
        check("R8 valids midrun", {62'h0, row_valid, mix_valid}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule